// File: doc/BRIEF.md
# Asynchronous Frame Transmitter

This block turns bytes into asynchronous serial frames on one output line. A producer writes characters through a valid/ready port into a 16-entry queue. The transmitter takes them out one at a time. For each one it sends a low start bit, then the data bits with the least significant first, then an optional parity bit, then a high stop period. The line stays high whenever nothing is being sent.

The frame format is set by static inputs: a character length of 5 to 8 bits, parity off, even or odd, and a stop period of 1, 1.5 or 2 bit times. A baud-tick input that pulses 16 times per bit period times every slot of the frame, which makes the half-bit stop length possible. When a frame ends and the queue still holds a character, the next start bit begins at once, so queued characters go out back to back. The fill level and an idle flag are brought out for the surrounding logic.

Top module: `async_frame_tx`

## Requirements
- R1: When no frame is being sent, `txd` is high. `tx_idle` is high exactly when no frame is in progress and the queue is empty. After reset, `txd`=1, `tx_idle`=1, `fill_level`=0 and `wr_ready`=1.
- R2: Each frame begins with one start bit: `txd` low for 16 baud ticks.
- R3: Every data bit and the parity bit lasts 16 baud ticks. Data bits are sent least significant bit first.
- R4: `cfg_len` sets the character length: 0 gives 5 bits, 1 gives 6, 2 gives 7, 3 gives 8. Only that many low-order bits of the queued byte are sent; the higher bits have no effect on the line.
- R5: With `cfg_parity_en`=1, one parity bit follows the last data bit. It is computed over the configured data bits only. With `cfg_parity_odd`=0 the ones count of data plus parity is even; with `cfg_parity_odd`=1 it is odd.
- R6: With `cfg_parity_en`=0, the stop period follows the last data bit directly.
- R7: The stop period is high. It lasts 16 ticks for `cfg_stop`=0, 24 ticks for 1, and 32 ticks for 2 or 3. The frame ends when the stop period ends.
- R8: The queue holds 16 characters. A write is accepted on a clock edge with `wr_valid` and `wr_ready` both high, also while a frame is being sent. `fill_level` counts the stored characters.
- R9: When the queue holds 16 characters, `wr_ready` is low. A write offered then is refused, and the stored characters and their order are unchanged.
- R10: If the queue is not empty when a stop period ends, the next start bit begins on the very next tick period, with no idle time between frames.
- R11: The format inputs are captured when a character is taken for sending. A change made during a frame applies from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse, 16 per bit period |
| wr_data | input | 8 | Character to queue |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Queue can accept a write |
| cfg_len | input | 2 | Character length code (5 + code bits) |
| cfg_parity_en | input | 1 | Insert parity bit |
| cfg_parity_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_stop | input | 2 | Stop length: 0 = 1 bit, 1 = 1.5 bits, 2/3 = 2 bits |
| txd | output | 1 | Serial line, idle high |
| fill_level | output | 5 | Number of queued characters |
| tx_idle | output | 1 | No frame in progress and queue empty |

## Verification
A character is taken on the first baud tick after it is queued. `txd` falls one clock later, on the edge that loads the start slot. From that falling edge, every slot boundary lies an exact multiple of 16 tick periods later. The bench runs its ticks at a fixed period and counts clock cycles from the observed fall. It samples each bit in the middle of its slot, and it checks the clock just before and the clock at the computed frame end, where either the next start bit or `tx_idle` must appear. `wr_ready` and `fill_level` change on the clock edge after a write or a take. The bench reads them at the next falling clock edge.

// File: rtl/atx_pkg.sv
package atx_pkg;

  localparam int unsigned CHAR_W = 8;
  localparam logic [5:0] BIT_TICKS = 6'd16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    logic       par_odd;
    logic [1:0] stop;
  } frame_cfg_t;

  // Number of data bits for a length code.
  function automatic logic [3:0] char_bits(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

  // Stop period in ticks for a stop code.
  function automatic logic [5:0] stop_ticks(input logic [1:0] code);
    case (code)
      2'd0:    return BIT_TICKS;
      2'd1:    return BIT_TICKS + (BIT_TICKS >> 1);
      default: return BIT_TICKS << 1;
    endcase
  endfunction

  // Parity over the configured low-order bits.
  function automatic logic par_bit(input logic [CHAR_W-1:0] d,
                                   input logic [1:0] code,
                                   input logic odd);
    logic [CHAR_W-1:0] mask;
    mask = 8'hFF >> (2'd3 - code);
    return (^(d & mask)) ^ odd;
  endfunction

endpackage

// File: rtl/atx_fifo.sv
module atx_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             push,
  input  logic [WIDTH-1:0]                 push_data,
  input  logic                             pop,
  output logic [WIDTH-1:0]                 pop_data,
  output logic [$clog2(DEPTH+1)-1:0]       level,
  output logic                             full,
  output logic                             empty
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push) wp <= wrap_inc(wp);
      if (pop)  rp <= wrap_inc(rp);
      if (push && !pop)      level <= level + 1'b1;
      else if (pop && !push) level <= level - 1'b1;
    end
  end

  assign pop_data = mem[rp];
  assign full     = (level == CW'(DEPTH));
  assign empty    = (level == '0);
endmodule

// File: rtl/atx_seq.sv
module atx_seq
  import atx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              avail,
  input  logic [CHAR_W-1:0] char_in,
  input  frame_cfg_t        cfg,
  output logic              take,
  output logic              frame_end,
  output tx_state_e         state,
  output logic              txd
);
  logic [5:0]        ph;
  logic [2:0]        idx;
  logic [CHAR_W-1:0] shreg;
  logic              par_q;
  frame_cfg_t        fcfg;
  logic [5:0]        slot_len;
  logic              slot_last;
  logic              last_data;

  assign slot_len  = (state == ST_STOP) ? stop_ticks(fcfg.stop) : BIT_TICKS;
  assign slot_last = tick && (ph == slot_len - 6'd1);
  assign last_data = ({1'b0, idx} == char_bits(fcfg.len) - 4'd1);
  assign frame_end = (state == ST_STOP) && slot_last;
  assign take      = tick && avail && ((state == ST_IDLE) || frame_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ph    <= '0;
      idx   <= '0;
      shreg <= '0;
      par_q <= 1'b0;
      fcfg  <= '0;
    end else if (take) begin
      state <= ST_START;
      ph    <= '0;
      idx   <= '0;
      shreg <= char_in;
      fcfg  <= cfg;
      par_q <= par_bit(char_in, cfg.len, cfg.par_odd);
    end else if (tick && state != ST_IDLE) begin
      if (slot_last) begin
        ph <= '0;
        case (state)
          ST_START: state <= ST_DATA;
          ST_DATA: begin
            if (last_data) state <= fcfg.par_en ? ST_PAR : ST_STOP;
            else begin
              idx   <= idx + 3'd1;
              shreg <= shreg >> 1;
            end
          end
          ST_PAR:  state <= ST_STOP;
          default: state <= ST_IDLE;
        endcase
      end else begin
        ph <= ph + 6'd1;
      end
    end
  end

  always_comb begin
    case (state)
      ST_START: txd = 1'b0;
      ST_DATA:  txd = shreg[0];
      ST_PAR:   txd = par_q;
      default:  txd = 1'b1;
    endcase
  end
endmodule

// File: rtl/async_frame_tx.sv
module async_frame_tx
  import atx_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         baud_tick,
  input  logic [7:0]                   wr_data,
  input  logic                         wr_valid,
  output logic                         wr_ready,
  input  logic [1:0]                   cfg_len,
  input  logic                         cfg_parity_en,
  input  logic                         cfg_parity_odd,
  input  logic [1:0]                   cfg_stop,
  output logic                         txd,
  output logic [$clog2(DEPTH+1)-1:0]   fill_level,
  output logic                         tx_idle
);
  logic              push_w, take_w, frame_end_w, full_w, empty_w;
  logic [CHAR_W-1:0] head_w;
  tx_state_e         state_w;
  frame_cfg_t        cfg_w;

  assign cfg_w    = '{len: cfg_len, par_en: cfg_parity_en,
                      par_odd: cfg_parity_odd, stop: cfg_stop};
  assign wr_ready = !full_w;
  assign push_w   = wr_valid && !full_w;
  assign tx_idle  = (state_w == ST_IDLE) && empty_w;

  atx_fifo #(.WIDTH(CHAR_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(push_w), .push_data(wr_data),
    .pop(take_w), .pop_data(head_w),
    .level(fill_level), .full(full_w), .empty(empty_w)
  );

  atx_seq u_seq (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick),
    .avail(!empty_w), .char_in(head_w), .cfg(cfg_w),
    .take(take_w), .frame_end(frame_end_w), .state(state_w), .txd(txd)
  );
endmodule

// File: rtl/atx_checker.sv
module atx_checker
  import atx_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        txd,
  input logic                        wr_ready,
  input logic [$clog2(DEPTH+1)-1:0]  fill_level,
  input logic                        tx_idle,
  input logic                        push,
  input logic                        take,
  input logic                        frame_end,
  input tx_state_e                   state
);
  localparam int unsigned CW = $clog2(DEPTH+1);

  AST_MARK_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> txd); // R1
  AST_IDLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> (txd && fill_level == '0)); // R1
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!txd && state == ST_START)); // R2
  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOP) |-> txd); // R7
  AST_FILL_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !take) |=> (fill_level == $past(fill_level) + 1'b1)); // R8
  AST_TAKE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (fill_level != '0)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level == CW'(DEPTH)) |-> !wr_ready); // R9
  AST_FULL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level == CW'(DEPTH) && !take) |=> (fill_level == CW'(DEPTH))); // R9
  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && fill_level != '0) |=> (state == ST_START && !txd)); // R10
endmodule

bind async_frame_tx atx_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .wr_ready(wr_ready),
  .fill_level(fill_level), .tx_idle(tx_idle), .push(push_w),
  .take(take_w), .frame_end(frame_end_w), .state(state_w)
);

// File: tb/async_frame_tx_test.sv
module async_frame_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int TD = 2;

  typedef struct packed {
    logic [7:0] d;
    logic [1:0] len;
    logic       pe;
    logic       po;
    logic [1:0] st;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'h55, 2'd3, 1'b0, 1'b0, 2'd0},
    '{8'hA7, 2'd3, 1'b1, 1'b0, 2'd2},
    '{8'hFF, 2'd0, 1'b1, 1'b1, 2'd1},
    '{8'hE0, 2'd0, 1'b1, 1'b0, 2'd0},
    '{8'h3C, 2'd1, 1'b1, 1'b1, 2'd3},
    '{8'h81, 2'd2, 1'b0, 1'b0, 2'd1},
    '{8'h6B, 2'd2, 1'b1, 1'b1, 2'd2},
    '{8'h00, 2'd3, 1'b1, 1'b1, 2'd0}
  };

  logic clk = 0, rst_n = 0, baud_tick = 0;
  logic [7:0] wr_data = 0;
  logic wr_valid = 0, wr_ready;
  logic [1:0] cfg_len = 3, cfg_stop = 0;
  logic cfg_parity_en = 0, cfg_parity_odd = 0;
  logic txd, tx_idle;
  logic [4:0] fill_level;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit tick_en = 1, done = 0;

  async_frame_tx uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .cfg_len(cfg_len), .cfg_parity_en(cfg_parity_en),
    .cfg_parity_odd(cfg_parity_odd), .cfg_stop(cfg_stop),
    .txd(txd), .fill_level(fill_level), .tx_idle(tx_idle)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  initial begin
    int tc;
    tc = 0;
    forever begin
      @(negedge clk);
      tc = (tc + 1) % TD;
      baud_tick = tick_en && (tc == 0);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wait_to(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d, output bit acc);
    wr_data  = d;
    wr_valid = 1;
    acc      = wr_ready;
    @(negedge clk);
    wr_valid = 0;
  endtask

  // Receive one frame and check its content and length.
  task automatic rx_frame(input logic [7:0] d, input logic [1:0] len,
                          input bit pe, input bit po, input logic [1:0] st,
                          input bit nxt);
    int t0, n, p, stp, total, ones;
    logic [7:0] got, want;
    n    = 5 + int'(len);
    p    = pe ? 1 : 0;
    stp  = (st == 0) ? 16 : (st == 1) ? 24 : 32;
    total = (1 + n + p) * 16 + stp;
    while (txd !== 1'b0) @(negedge clk);
    t0 = cyc;
    wait_to(t0 + 8 * TD);
    chk(txd == 1'b0, "R2 start bit low", txd, 0);
    got = 0; want = 0; ones = 0;
    for (int i = 0; i < n; i++) begin
      wait_to(t0 + (16 * (1 + i) + 8) * TD);
      got[i]  = txd;
      want[i] = d[i];
      ones   += d[i];
    end
    chk(got == want, "R3 R4 data bits", got, want);
    if (pe) begin
      wait_to(t0 + (16 * (1 + n) + 8) * TD);
      chk(txd == ((ones % 2 == 1) ^ po), "R5 parity bit", txd, (ones % 2 == 1) ^ po);
    end
    wait_to(t0 + (16 * (1 + n + p) + 8) * TD);
    chk(txd == 1'b1, "R6 R7 stop high after last bit", txd, 1);
    wait_to(t0 + total * TD - 1);
    chk(txd == 1'b1 && tx_idle == 1'b0, "R7 stop period still running",
        {txd, tx_idle}, 2'b10);
    wait_to(t0 + total * TD);
    if (nxt) chk(txd == 1'b0, "R10 next start with no gap", txd, 0);
    else     chk(txd == 1'b1 && tx_idle == 1'b1, "R1 R7 idle at frame end",
                 {txd, tx_idle}, 2'b11);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit acc;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1, R8: reset state
    chk(txd == 1 && tx_idle == 1, "R1 reset line and idle", {txd, tx_idle}, 2'b11);
    chk(fill_level == 0 && wr_ready == 1, "R8 reset queue empty",
        {fill_level, wr_ready}, 6'b000001);

    // Vector table: one frame per format
    foreach (VECS[k]) begin
      cfg_len = VECS[k].len; cfg_parity_en = VECS[k].pe;
      cfg_parity_odd = VECS[k].po; cfg_stop = VECS[k].st;
      push(VECS[k].d, acc);
      chk(acc, "R8 write accepted", acc, 1);
      rx_frame(VECS[k].d, VECS[k].len, VECS[k].pe, VECS[k].po, VECS[k].st, 1'b0);
    end

    // R9: fill the queue with ticks stopped, then offer one more
    tick_en = 0;
    cfg_len = 3; cfg_parity_en = 0; cfg_stop = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 16; i++) push(8'h10 + 8'(i), acc);
    chk(fill_level == 16, "R8 sixteen stored", fill_level, 16);
    chk(wr_ready == 0, "R9 ready low when full", wr_ready, 0);
    push(8'hEE, acc);
    chk(acc == 0 && fill_level == 16, "R9 write refused when full",
        {acc, fill_level}, 16);
    tick_en = 1;
    fork
      begin
        for (int i = 0; i < 16; i++) rx_frame(8'h10 + 8'(i), 2'd3, 0, 0, 2'd0, 1'b1);
        rx_frame(8'hC3, 2'd3, 0, 0, 2'd0, 1'b0);
      end
      begin
        bit a2;
        repeat (60) @(negedge clk);
        push(8'hC3, a2);
        chk(a2 == 1, "R8 write during transmission", a2, 1);
      end
    join

    // R11: format change during a frame applies to the next one
    tick_en = 0;
    cfg_len = 2; cfg_parity_en = 1; cfg_parity_odd = 1; cfg_stop = 2;
    repeat (3) @(negedge clk);
    push(8'h5A, acc);
    push(8'h33, acc);
    tick_en = 1;
    fork
      begin
        rx_frame(8'h5A, 2'd2, 1, 1, 2'd2, 1'b1); // R11 old format kept
        rx_frame(8'h33, 2'd0, 0, 0, 2'd1, 1'b0); // R11 new format used
      end
      begin
        repeat (40) @(negedge clk);
        cfg_len = 0; cfg_parity_en = 0; cfg_parity_odd = 0; cfg_stop = 1;
      end
    join

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule